// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is one slice of a memory-mapped general-purpose I/O controller. It serves a single 32-bit register group that holds four 8-bit ports, so pin `n` of port `k` is bit `k*8 + n` in every register of the group. Software sets an output latch and a direction mask per pin. The pins themselves appear as three separate vectors: the sampled input level, the output value and the output enable. Pin muxing and any debounce filter sit outside this block and feed `pin_in`.

Each pin also has an interrupt sensor. Three parallel type words select the trigger for each pin: rising edge, falling edge, either edge, high level or low level. The sensor works on a two-flop synchronized copy of the pin. It records events in a sticky status word. Software clears a status bit by writing 1 to it. A single interrupt line is the OR over every pin whose status is set and whose enable bit is set.

The register interface is a simple synchronous bus with byte addresses. A write takes effect on the clock edge of its cycle. Read data is registered and is valid in the cycle after the read cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0 and `irq` is 0, so every pin starts as an input with its interrupt disabled.
- R2: A write to offset 0x00 sets the output latch driven on `pin_out`. A write to offset 0x04 sets the direction mask driven on `pin_oe`, where 1 means the pin is an output. Both take effect at the edge of the write cycle.
- R3: A read of offset 0x00 returns the pin level taken from `pin_in` through two synchronizing flops, for every pin regardless of its direction.
- R4: The enable word (0x08), type words A (0x0C), B (0x10) and C (0x14) and the status word (0x18) read back what they hold. Any other offset reads 0. `bus_rdata` is valid in the cycle after the read cycle and is 0 after any cycle without a read.
- R5: With B=0 and C=0 for a pin, A=1 senses a rising edge and A=0 senses a falling edge. The status bit is set at the third clock edge after the pin changes.
- R6: With B=0 and C=1 for a pin, either edge sets its status bit, whatever A holds.
- R7: With B=1 for a pin, the pin is level sensed: A=1 means high, A=0 means low. While that level holds, the status bit is set again at every edge, so a clear does not take effect.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A status bit stays set until it is cleared. An event in the clearing cycle wins over the clear.
- R9: Status bits are set whether or not the pin is enabled. `irq` is 1 exactly when some pin has both its status and its enable bit set, and it follows register changes without an extra cycle.
- R10: Every register uses the same pin map: pin `n` of port `k` is bit `k*8 + n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address within the group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable (direction mask) |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change driven before edge 1 reaches the synchronized level at edge 2, so a data read issued after that returns it. An edge or level event sets status at edge 3. A register write lands at the edge of its cycle, and `irq` follows one delta later. Read data is registered, so each expected read value goes into a queue when the read is issued, and the monitor compares it at the falling edge after the read's clock edge. Interrupt checks are taken at falling edges, counted from the edge that changes the register. The `irq` timing check samples it low after edge 2 and high after edge 3.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt bank: register offsets and
// the bus address width. Offsets are byte addresses within the group.
package gpio_irq_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TYPE_A = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TYPE_B = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TYPE_C = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h18;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for the pin vector, plus one more flop that
// holds the previous synchronized sample for edge detection.
// Assumes: pin_in may change at any time relative to clk.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);
    logic [W-1:0] meta_q;

    // Two synchronizing stages and the previous-sample stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q     <= '0;
            level      <= '0;
            level_prev <= '0;
        end else begin
            meta_q     <= pin_async;
            level      <= meta_q;
            level_prev <= level;
        end
    end
endmodule

// File: rtl/gpio_trigger_detect.sv
// Per-pin trigger decode and the sticky write-one-to-clear status word.
// Type coding per pin: B=1 level sensing (A picks high/low); B=0 edge
// sensing, where C=1 means either edge and otherwise A picks rise/fall.
// Assumes: level/level_prev come from the synchronizer; clr_mask is a
// one-cycle pulse from the register file.
module gpio_trigger_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] level_prev,
    input  logic [W-1:0] typ_a,
    input  logic [W-1:0] typ_b,
    input  logic [W-1:0] typ_c,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] evt;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_i;
        logic fall_i;
        logic evt_i;

        // Decode this pin's trigger mode into a one-cycle event.
        always_comb begin
            rise_i = level[i] & ~level_prev[i];
            fall_i = ~level[i] & level_prev[i];
            if (typ_b[i]) begin
                evt_i = typ_a[i] ? level[i] : ~level[i];
            end else if (typ_c[i]) begin
                evt_i = rise_i | fall_i;
            end else begin
                evt_i = typ_a[i] ? rise_i : fall_i;
            end
        end

        assign evt[i] = evt_i;
    end

    // Sticky status: clear on written ones, an event in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | evt;
        end
    end

    // R8: bits not being cleared stay set.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

    // R8: a cleared bit with no coincident event reads 0 afterwards.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr_mask & ~evt)) == '0));

    // R5: a status bit never appears without an event.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio_reg_file.sv
// Register file and read mux for one GPIO group: output latch, direction,
// enable, three type words, and the status clear pulse.
// Assumes: word-aligned byte addresses; reads return data one cycle later.
module gpio_reg_file
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      status,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      en_q,
    output logic [W-1:0]      typ_a_q,
    output logic [W-1:0]      typ_b_q,
    output logic [W-1:0]      typ_c_q,
    output logic [W-1:0]      clr_mask
);
    logic         wr_en;
    logic         rd_en;
    logic [W-1:0] rd_mux;

    // Decode bus strobes.
    always_comb begin
        wr_en = bus_sel & bus_wr;
        rd_en = bus_sel & ~bus_wr;
    end

    // Status clear pulse: written ones of a status write.
    always_comb begin
        clr_mask = (wr_en && bus_addr == OFS_STATUS) ? bus_wdata : '0;
    end

    // Writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            en_q    <= '0;
            typ_a_q <= '0;
            typ_b_q <= '0;
            typ_c_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_DATA:   out_q   <= bus_wdata;
                OFS_DIR:    dir_q   <= bus_wdata;
                OFS_ENABLE: en_q    <= bus_wdata;
                OFS_TYPE_A: typ_a_q <= bus_wdata;
                OFS_TYPE_B: typ_b_q <= bus_wdata;
                OFS_TYPE_C: typ_c_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Read selection; data offset returns the synchronized pin level.
    always_comb begin
        case (bus_addr)
            OFS_DATA:   rd_mux = level;
            OFS_DIR:    rd_mux = dir_q;
            OFS_ENABLE: rd_mux = en_q;
            OFS_TYPE_A: rd_mux = typ_a_q;
            OFS_TYPE_B: rd_mux = typ_b_q;
            OFS_TYPE_C: rd_mux = typ_c_q;
            OFS_STATUS: rd_mux = status;
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data, zero when no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_en ? rd_mux : '0;
        end
    end

    // R2: a direction write is visible on the next cycle.
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));

    // R4: read data is zero after a cycle without a read.
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
// Top of the GPIO interrupt bank: one 32-bit group of four 8-bit ports.
// Pin n of port k is bit k*8+n. irq is the OR of status AND enable.
// Assumes: pin_in comes from an external mux/filter; synchronous reset.
module gpio_irq_bank #(
    parameter int PORTS  = 4,
    parameter int PORT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [PORTS*PORT_W-1:0] bus_wdata,
    output logic [PORTS*PORT_W-1:0] bus_rdata,
    input  logic [PORTS*PORT_W-1:0] pin_in,
    output logic [PORTS*PORT_W-1:0] pin_out,
    output logic [PORTS*PORT_W-1:0] pin_oe,
    output logic                    irq
);
    localparam int W = PORTS * PORT_W;

    logic [W-1:0] level;
    logic [W-1:0] level_prev;
    logic [W-1:0] status;
    logic [W-1:0] en_q;
    logic [W-1:0] typ_a;
    logic [W-1:0] typ_b;
    logic [W-1:0] typ_c;
    logic [W-1:0] clr_mask;

    gpio_pin_sync #(.W(W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (pin_in),
        .level      (level),
        .level_prev (level_prev)
    );

    gpio_reg_file #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level),
        .status    (status),
        .out_q     (pin_out),
        .dir_q     (pin_oe),
        .en_q      (en_q),
        .typ_a_q   (typ_a),
        .typ_b_q   (typ_b),
        .typ_c_q   (typ_c),
        .clr_mask  (clr_mask)
    );

    gpio_trigger_detect #(.W(W)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .level_prev (level_prev),
        .typ_a      (typ_a),
        .typ_b      (typ_b),
        .typ_c      (typ_c),
        .clr_mask   (clr_mask),
        .status     (status)
    );

    // Combined interrupt from pending and enabled pins.
    always_comb begin
        irq = |(status & en_q);
    end

    // R9: with no pin enabled the interrupt stays low.
    a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int errors = 0;
    int checks = 0;
    logic rd_q = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    // Marks cycles whose read data is due at the following falling edge.
    always @(posedge clk) rd_q <= bus_sel & ~bus_wr;

    // Monitor: pops expected read data and compares it.
    always @(negedge clk) begin
        if (rd_q) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pin_out, 32'h0, "R1 pin_out");
        chk(pin_oe, 32'h0, "R1 pin_oe");
        chk({31'h0, irq}, 32'h0, "R1 irq");
        rd(8'h00, 32'h0, "R1 data");
        rd(8'h04, 32'h0, "R1 dir");
        rd(8'h08, 32'h0, "R1 enable");
        rd(8'h0C, 32'h0, "R1 typeA");
        rd(8'h10, 32'h0, "R1 typeB");
        rd(8'h14, 32'h0, "R1 typeC");
        rd(8'h18, 32'h0, "R1 status");

        // R2 output latch and direction
        wr(8'h00, 32'hA5C3_1234);
        chk(pin_out, 32'hA5C3_1234, "R2 pin_out");
        wr(8'h04, 32'hFFFF_0000);
        chk(pin_oe, 32'hFFFF_0000, "R2 pin_oe");
        rd(8'h04, 32'hFFFF_0000, "R4 dir readback");

        // R3 data read returns pin level, not the latch
        pin_in = 32'h5A5A_0F0F;
        repeat (3) @(negedge clk);
        rd(8'h00, 32'h5A5A_0F0F, "R3 pin level");
        rd(8'h1C, 32'h0, "R4 unmapped offset");

        // Return pins low, configure modes, clear status
        pin_in = 32'h0;
        repeat (3) @(negedge clk);
        wr(8'h0C, 32'h0000_0109);  // A: bits 0,3,8
        wr(8'h10, 32'h0000_0018);  // B: bits 3,4 level
        wr(8'h14, 32'h0000_0004);  // C: bit 2 both
        rd(8'h0C, 32'h0000_0109, "R4 typeA readback");
        rd(8'h10, 32'h0000_0018, "R4 typeB readback");
        rd(8'h14, 32'h0000_0004, "R4 typeC readback");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0000_0010, "R7 level low persists after clear");

        // Raise pins 0..4 and port1 pin0 (bit 8)
        pin_in = 32'h0000_011F;
        repeat (3) @(negedge clk);
        rd(8'h18, 32'h0000_011D, "R5 R6 R7 R10 rising/both/high");

        wr(8'h18, 32'h0000_011D);
        rd(8'h18, 32'h0000_0008, "R7 level high re-sets after clear");

        pin_in = 32'h0;
        repeat (3) @(negedge clk);
        rd(8'h18, 32'h0000_001E, "R5 R6 falling/both/low");

        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0000_0010, "R8 clear all but active level");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h0000_0010, "R8 zero write no effect");

        // R9 enable gating and irq timing
        chk({31'h0, irq}, 32'h0, "R9 status without enable");
        wr(8'h08, 32'h0000_0010);
        chk({31'h0, irq}, 32'h1, "R9 enable raises irq");
        wr(8'h08, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R9 other enable no irq");
        rd(8'h08, 32'h0000_0001, "R4 enable readback");
        pin_in = 32'h0000_0001;
        repeat (2) @(negedge clk);
        chk({31'h0, irq}, 32'h0, "R5 irq not before third edge");
        @(negedge clk);
        chk({31'h0, irq}, 32'h1, "R5 irq at third edge");
        wr(8'h18, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R8 clear drops irq");
        rd(8'h18, 32'h0000_0010, "R8 only bit0 cleared");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule